// File: doc/BRIEF.md
# Serial Engine Run/Pause State Controller

This block keeps the operating state of a serial peripheral engine and gates that engine's data path. Software uses a small register port to ask for one of three states: reset, run or pause. It reads back the current state code, a valid flag and an engine-ready flag. A state change is not applied at once. The request first waits a fixed number of bus-clock cycles. It then crosses into the serial-clock domain by a toggle handshake, is applied there, and is acknowledged back. The valid flag reads 0 for the whole exchange. Software must poll valid before it asks for another state.

The block also collects event flags: a bus-error input, a set of core error inputs and two FIFO service events. It drives a level interrupt from these flags. A soft-reset register forces the reset state and clears every pending flag. Writing the reset state code also clears a pending bus error. In the serial domain the block drives two outputs. The run enable is high only in the run state. The FIFO-clear output is high only in the reset state, so pause freezes the engine and keeps the FIFO contents.

The block has no streaming interface. Every pin is a plain control or status signal, and a register write is taken in the cycle it is presented.

Top module: `pstate_ctrl`

## Requirements
- R1: After reset the state register reads code 0 (reset) with valid (bit 2) at 1. run_en_o is 0, fifo_clr_o is 1 and irq_o is 0.
- R2: A write to address 0 is accepted only while valid is 1 and only with a code of 0 (reset), 1 (run) or 3 (pause). An accepted write drops valid and, once the change completes, the new code reads back in bits 1:0. A write of code 2, or any state write while valid is 0, has no effect.
- R3: After an accepted state write, valid stays 0 for at least BUS_WAIT bus-clock cycles. It also stays 0 through the serial-domain synchronizer and the return acknowledge, and then reads 1 again.
- R4: The serial-domain outputs follow the applied state. run_en_o is high only in run. fifo_clr_o is high only in reset. In pause both are low.
- R5: Bit 4 of the state register reports mst_ready_i after a synchronizer of SYNC_STAGES bus-clock flops.
- R6: Writing 1 in bit 0 at address 1 sets the state readback to 0 in the next cycle. It drops valid until the serial side has returned to reset, clears every event flag, and works even while a change is in flight. Writing 0 there has no effect.
- R7: Events set flags in the register at address 2. bus_err_i sets bit 0. core_err_i[k] sets bit 2+k. out_svc_i sets bit 8. in_svc_i sets bit 9.
- R8: Writing 1 to bits 2 to 6, 8 or 9 of address 2 clears those flags. Bit 0 is not cleared this way.
- R9: irq_o is high while any of these holds: the bus-error flag, a service flag, or a core error flag whose enable bit is set. The enable bit for core error k is bit 2+k of address 3.
- R10: A write of reset code 0 to address 0 clears the bus-error flag in the next cycle.
- R11: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-interface clock |
| rst_n | input | 1 | Active-low reset, bus domain |
| sclk | input | 1 | Serial-master clock |
| srst_n | input | 1 | Active-low reset, serial domain |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address: 0 state, 1 soft reset, 2 flags, 3 error enables |
| reg_wdata | input | DW | Write data |
| reg_raddr | input | 2 | Read address, same map |
| reg_rdata | output | DW | Read data, combinational from reg_raddr |
| mst_ready_i | input | 1 | Serial master engine ready, serial domain |
| bus_err_i | input | 1 | Bus protocol error event |
| core_err_i | input | CERR_W | Core error events |
| in_svc_i | input | 1 | Input FIFO service event |
| out_svc_i | input | 1 | Output FIFO service event |
| run_en_o | output | 1 | Engine run enable, serial domain |
| fifo_clr_o | output | 1 | FIFO discard, serial domain |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check these rules on every cycle:
- valid stays low while a change is in flight and rises only after the acknowledge.
- The target cannot be overwritten during the launch wait.
- The serial-side state moves only on a detected request.
- A soft reset always leaves the state and flags cleared.
- Flag set, write-1-to-clear and the clear on a reset-code write behave as required.
- An event always wins over a clear in the same cycle.

Only the bench scenarios can show the rest:
- The end-to-end latency across both clocks.
- That an illegal code or a write while busy leaves the final readback unchanged.
- That a soft reset during a pending acknowledge still ends in the reset state.
- The exact interrupt level for each combination of enables and flags.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    RA_STATE  = 2'd0,
    RA_SRESET = 2'd1,
    RA_FLAGS  = 2'd2,
    RA_ERREN  = 2'd3
  } regaddr_e;

  localparam int VALID_BIT  = 2;
  localparam int READY_BIT  = 4;
  localparam int BUSERR_BIT = 0;
  localparam int CERR_LSB   = 2;
  localparam int OSVC_BIT   = 8;
  localparam int ISVC_BIT   = 9;

  function automatic logic code_legal(input logic [1:0] code);
    return code != 2'd2;
  endfunction

endpackage

// File: rtl/pstate_sync.sv
module pstate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pstate_bus_side.sv
module pstate_bus_side
  import pstate_pkg::*;
#(
  parameter int BUS_WAIT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    st_wr,
  input  logic [1:0] st_code,
  input  logic    sreset,
  input  logic    ack_tog_i,
  output pstate_e cur_state,
  output logic    valid,
  output pstate_e tgt_o,
  output logic    req_tog_o
);
  localparam int CNT_W = (BUS_WAIT > 1) ? $clog2(BUS_WAIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUS_WAIT-1);

  typedef enum logic [1:0] {P_IDLE, P_LAUNCH, P_WAITACK} phase_e;

  phase_e phase;
  logic [CNT_W-1:0] cnt;
  logic ack_s, ack_last, pend_rst;
  logic ack_seen;

  pstate_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tog_i), .q(ack_s)
  );

  assign ack_seen = ack_s ^ ack_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      cnt       <= '0;
      valid     <= 1'b1;
      cur_state <= ST_RESET;
      tgt_o     <= ST_RESET;
      req_tog_o <= 1'b0;
      ack_last  <= 1'b0;
      pend_rst  <= 1'b0;
    end else begin
      case (phase)
        P_IDLE: begin
          if (sreset) begin
            cur_state <= ST_RESET;
            tgt_o     <= ST_RESET;
            valid     <= 1'b0;
            cnt       <= '0;
            phase     <= P_LAUNCH;
          end else if (st_wr && code_legal(st_code)) begin
            tgt_o <= pstate_e'(st_code);
            valid <= 1'b0;
            cnt   <= '0;
            phase <= P_LAUNCH;
          end
        end
        P_LAUNCH: begin
          if (sreset) begin
            cur_state <= ST_RESET;
            tgt_o     <= ST_RESET;
            cnt       <= '0;
          end else if (cnt == CNT_LAST) begin
            req_tog_o <= ~req_tog_o;
            phase     <= P_WAITACK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_WAITACK: begin
          if (ack_seen) begin
            ack_last <= ack_s;
            if (pend_rst || sreset) begin
              pend_rst  <= 1'b0;
              tgt_o     <= ST_RESET;
              cur_state <= ST_RESET;
              cnt       <= '0;
              phase     <= P_LAUNCH;
            end else begin
              cur_state <= tgt_o;
              valid     <= 1'b1;
              phase     <= P_IDLE;
            end
          end else if (sreset) begin
            pend_rst  <= 1'b1;
            cur_state <= ST_RESET;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  // R2: a state write during the launch wait cannot change the target
  a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_LAUNCH && st_wr && !sreset) |=> $stable(tgt_o));
  // R3: valid is low for the whole handshake
  a_r3_valid_low_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != P_IDLE) |-> !valid);
  // R3: valid only returns after an acknowledge was awaited
  a_r3_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(phase == P_WAITACK));
  // R6: soft reset always leaves reset in the readback
  a_r6_sreset_state: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (cur_state == ST_RESET && !valid));
endmodule

// File: rtl/pstate_eng_side.sv
module pstate_eng_side
  import pstate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    sclk,
  input  logic    srst_n,
  input  logic    req_tog_i,
  input  pstate_e tgt_i,
  output logic    ack_tog_o,
  output logic    run_en,
  output logic    fifo_clr
);
  pstate_e eng_state;
  logic req_s, req_last, req_seen;

  pstate_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(sclk), .rst_n(srst_n), .d(req_tog_i), .q(req_s)
  );

  assign req_seen = req_s ^ req_last;

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      eng_state <= ST_RESET;
      ack_tog_o <= 1'b0;
      req_last  <= 1'b0;
    end else if (req_seen) begin
      req_last  <= req_s;
      eng_state <= tgt_i;
      ack_tog_o <= ~ack_tog_o;
    end
  end

  assign run_en   = (eng_state == ST_RUN);
  assign fifo_clr = (eng_state == ST_RESET);

  // R4: the engine state moves only on a detected request
  a_r4_state_moves_on_req: assert property (@(posedge sclk) disable iff (!srst_n)
    (eng_state != $past(eng_state)) |-> $past(req_seen));
  // R4: every acknowledge reports the applied target
  a_r4_ack_carries_state: assert property (@(posedge sclk) disable iff (!srst_n)
    (ack_tog_o != $past(ack_tog_o)) |-> (eng_state == $past(tgt_i)));
endmodule

// File: rtl/pstate_flags.sv
module pstate_flags
  import pstate_pkg::*;
#(
  parameter int CERR_W = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sreset,
  input  logic              rst_code_wr,
  input  logic              fl_wr,
  input  logic [CERR_W-1:0] w1c_cerr,
  input  logic              w1c_osvc,
  input  logic              w1c_isvc,
  input  logic              en_wr,
  input  logic [CERR_W-1:0] en_wdata,
  input  logic              bus_err_i,
  input  logic [CERR_W-1:0] core_err_i,
  input  logic              in_svc_i,
  input  logic              out_svc_i,
  output logic [DW-1:0]     flags_word,
  output logic [CERR_W-1:0] en_q,
  output logic              irq
);
  logic [CERR_W-1:0] cerr_q;
  logic bus_err_q, osvc_q, isvc_q;

  generate
    for (genvar k = 0; k < CERR_W; k++) begin : g_cerr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cerr_q[k] <= 1'b0;
        else if (sreset)             cerr_q[k] <= 1'b0;
        else if (core_err_i[k])      cerr_q[k] <= 1'b1;
        else if (fl_wr && w1c_cerr[k]) cerr_q[k] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_err_q <= 1'b0;
      osvc_q    <= 1'b0;
      isvc_q    <= 1'b0;
      en_q      <= '0;
    end else begin
      if (sreset)           bus_err_q <= 1'b0;
      else if (bus_err_i)   bus_err_q <= 1'b1;
      else if (rst_code_wr) bus_err_q <= 1'b0;

      if (sreset)                osvc_q <= 1'b0;
      else if (out_svc_i)        osvc_q <= 1'b1;
      else if (fl_wr && w1c_osvc) osvc_q <= 1'b0;

      if (sreset)                isvc_q <= 1'b0;
      else if (in_svc_i)         isvc_q <= 1'b1;
      else if (fl_wr && w1c_isvc) isvc_q <= 1'b0;

      if (en_wr) en_q <= en_wdata;
    end
  end

  always_comb begin
    flags_word = '0;
    flags_word[BUSERR_BIT]          = bus_err_q;
    flags_word[CERR_LSB +: CERR_W]  = cerr_q;
    flags_word[OSVC_BIT]            = osvc_q;
    flags_word[ISVC_BIT]            = isvc_q;
  end

  assign irq = bus_err_q | osvc_q | isvc_q | (|(cerr_q & en_q));

  // R9: an enabled core error drives the interrupt next cycle
  a_r9_enabled_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|(core_err_i & en_q) && !sreset && !en_wr) |=> irq);
  // R8: write-one clears the output service flag
  a_r8_w1c_out_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr && w1c_osvc && !out_svc_i) |=> !osvc_q);
  // R10: reset-code write clears the bus error
  a_r10_rst_code_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_code_wr && !bus_err_i) |=> !bus_err_q);
  // R11: an event wins over a clear in the same cycle
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_i && !sreset) |=> isvc_q);
  // R6: soft reset empties all flags
  a_r6_sreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (!bus_err_q && !osvc_q && !isvc_q && cerr_q == '0));
endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CERR_W      = 5,
  parameter int BUS_WAIT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              srst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [1:0]        reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  input  logic              mst_ready_i,
  input  logic              bus_err_i,
  input  logic [CERR_W-1:0] core_err_i,
  input  logic              in_svc_i,
  input  logic              out_svc_i,
  output logic              run_en_o,
  output logic              fifo_clr_o,
  output logic              irq_o
);
  logic st_wr, sreset, fl_wr, en_wr, rst_code_wr;
  logic valid, req_tog, ack_tog, ready_s;
  pstate_e cur_state, tgt;
  logic [DW-1:0] flags_word;
  logic [CERR_W-1:0] en_q;
  logic unused_wbits;

  assign st_wr       = reg_wr && (reg_waddr == RA_STATE);
  assign sreset      = reg_wr && (reg_waddr == RA_SRESET) && reg_wdata[0];
  assign fl_wr       = reg_wr && (reg_waddr == RA_FLAGS);
  assign en_wr       = reg_wr && (reg_waddr == RA_ERREN);
  assign rst_code_wr = st_wr && (reg_wdata[1:0] == ST_RESET);
  assign unused_wbits = ^{reg_wdata[DW-1:ISVC_BIT+1], reg_wdata[CERR_LSB+CERR_W +: (OSVC_BIT-CERR_LSB-CERR_W)]};

  pstate_bus_side #(.BUS_WAIT(BUS_WAIT), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_code(reg_wdata[1:0]),
    .sreset(sreset), .ack_tog_i(ack_tog), .cur_state(cur_state),
    .valid(valid), .tgt_o(tgt), .req_tog_o(req_tog)
  );

  pstate_eng_side #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
    .sclk(sclk), .srst_n(srst_n), .req_tog_i(req_tog), .tgt_i(tgt),
    .ack_tog_o(ack_tog), .run_en(run_en_o), .fifo_clr(fifo_clr_o)
  );

  pstate_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(mst_ready_i), .q(ready_s)
  );

  pstate_flags #(.CERR_W(CERR_W), .DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .rst_code_wr(rst_code_wr),
    .fl_wr(fl_wr), .w1c_cerr(reg_wdata[CERR_LSB +: CERR_W]),
    .w1c_osvc(reg_wdata[OSVC_BIT]), .w1c_isvc(reg_wdata[ISVC_BIT]),
    .en_wr(en_wr), .en_wdata(reg_wdata[CERR_LSB +: CERR_W]),
    .bus_err_i(bus_err_i), .core_err_i(core_err_i), .in_svc_i(in_svc_i),
    .out_svc_i(out_svc_i), .flags_word(flags_word), .en_q(en_q), .irq(irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      RA_STATE: begin
        reg_rdata[1:0]       = cur_state;
        reg_rdata[VALID_BIT] = valid;
        reg_rdata[READY_BIT] = ready_s;
      end
      RA_FLAGS: reg_rdata = flags_word;
      RA_ERREN: reg_rdata[CERR_LSB +: CERR_W] = en_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R2: an illegal code never starts a change
  a_r2_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[1:0] == 2'd2 && valid) |=> valid);
endmodule

// File: tb/pstate_ctrl_test.sv
module pstate_ctrl_test;
  localparam int CLK_PERIOD  = 10;
  localparam int SCLK_PERIOD = 14;
  localparam int PINS = 4;

  logic clk = 1'b0, sclk = 1'b0, rst_n = 1'b0, srst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_waddr = 2'd0, reg_raddr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mst_ready_i = 1'b0, bus_err_i = 1'b0, in_svc_i = 1'b0, out_svc_i = 1'b0;
  logic [4:0] core_err_i = '0;
  logic run_en_o, fifo_clr_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    src;
    int    mask;
    int    exp;
    string tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SCLK_PERIOD/2) sclk = ~sclk;

  pstate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mst_ready_i(mst_ready_i), .bus_err_i(bus_err_i), .core_err_i(core_err_i),
    .in_svc_i(in_svc_i), .out_svc_i(out_svc_i),
    .run_en_o(run_en_o), .fifo_clr_o(fifo_clr_o), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = (it.src == PINS) ? {29'd0, irq_o, fifo_clr_o, run_en_o} : int'(reg_rdata);
        checks++;
        if ((act & it.mask) != it.exp) begin
          errors++;
          $display("FAIL %s src=%0d actual=%h expected=%h", it.tag, it.src, act & it.mask, it.exp);
        end
      end
    end
  end

  // driver: pins word is {irq, fifo_clr, run_en}
  task automatic chk(input int src, input int mask, input int exp, input string tag);
    item_t it;
    @(negedge clk);
    if (src != PINS) reg_raddr = src[1:0];
    it.src = src; it.mask = mask; it.exp = exp; it.tag = tag;
    q.push_back(it);
    #3;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    reg_waddr = addr[1:0];
    reg_wdata = data;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      reg_raddr = 2'd0;
      #1;
      if (reg_rdata[2]) break;
      n++;
    end
  endtask

  task automatic go(input int code);
    int n;
    wr(0, code);
    wait_valid(n);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    srst_n = 1'b1;

    // R1 reset state
    chk(0, 32'h17, 32'h04, "R1 state after reset");
    chk(PINS, 7, 3'b010, "R1 pins after reset");
    chk(2, 32'h37d, 0, "R1 flags after reset");

    // R5 ready bit
    mst_ready_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(0, 32'h10, 32'h10, "R5 ready bit");

    // R2 / R3 / R4 run
    wr(0, 1);
    chk(0, 32'h04, 32'h00, "R2 valid drops after accepted write");
    wait_valid(n);
    checks++;
    if (n < 5 || n > 60) begin
      errors++;
      $display("FAIL R3 valid low cycles actual=%0d expected=5..60", n);
    end
    chk(0, 32'h17, 32'h15, "R2 run code read back");
    chk(PINS, 7, 3'b001, "R4 run pins");

    // R4 pause
    go(3);
    chk(0, 32'h17, 32'h17, "R4 pause code read back");
    chk(PINS, 7, 3'b000, "R4 pause keeps fifo");

    // R2 illegal code ignored
    wr(0, 2);
    repeat (12) @(negedge clk);
    chk(0, 32'h17, 32'h17, "R2 illegal code ignored");

    // R2 write while busy ignored
    wr(0, 1);
    wr(0, 3);
    wait_valid(n);
    chk(0, 32'h17, 32'h15, "R2 busy write ignored");
    chk(PINS, 7, 3'b001, "R2 busy write pins");

    // R7 / R9 / R8 / R11 flags
    @(negedge clk);
    core_err_i = 5'b00010;
    in_svc_i = 1'b1;
    @(negedge clk);
    core_err_i = '0;
    in_svc_i = 1'b0;
    chk(2, 32'h37d, 32'h208, "R7 core error and input service set");
    chk(PINS, 7, 3'b101, "R9 service flag raises irq");
    wr(2, 32'h200);
    chk(2, 32'h37d, 32'h008, "R8 clear input service");
    chk(PINS, 7, 3'b001, "R9 disabled core error no irq");
    wr(3, 32'h008);
    chk(3, 32'h7c, 32'h008, "R9 enable readback");
    chk(PINS, 7, 3'b101, "R9 enabled core error raises irq");
    @(negedge clk);
    reg_waddr = 2'd2;
    reg_wdata = 32'h008;
    reg_wr = 1'b1;
    core_err_i = 5'b00010;
    @(negedge clk);
    reg_wr = 1'b0;
    core_err_i = '0;
    chk(2, 32'h37d, 32'h008, "R11 set wins over clear");
    wr(2, 32'h008);
    chk(2, 32'h37d, 32'h000, "R8 core error cleared");
    chk(PINS, 7, 3'b001, "R9 irq low after clear");

    // R10 bus error
    @(negedge clk);
    bus_err_i = 1'b1;
    @(negedge clk);
    bus_err_i = 1'b0;
    chk(2, 32'h37d, 32'h001, "R7 bus error set");
    chk(PINS, 7, 3'b101, "R9 bus error irq");
    wr(2, 32'h001);
    chk(2, 32'h37d, 32'h001, "R8 bus error not write-one-clear");
    wr(0, 0);
    chk(2, 32'h37d, 32'h000, "R10 reset code clears bus error");
    wait_valid(n);
    chk(0, 32'h17, 32'h14, "R10 reset state reached");
    chk(PINS, 7, 3'b010, "R4 reset pins");

    // R6 soft reset
    go(1);
    @(negedge clk);
    out_svc_i = 1'b1;
    @(negedge clk);
    out_svc_i = 1'b0;
    chk(2, 32'h37d, 32'h100, "R7 output service set");
    wr(1, 1);
    chk(0, 32'h07, 32'h00, "R6 soft reset readback");
    chk(2, 32'h37d, 32'h000, "R6 soft reset clears flags");
    wait_valid(n);
    chk(0, 32'h17, 32'h14, "R6 soft reset completes");
    chk(PINS, 7, 3'b010, "R6 soft reset pins");

    go(1);
    wr(1, 0);
    repeat (12) @(negedge clk);
    chk(0, 32'h17, 32'h15, "R6 zero write ignored");

    wr(0, 3);
    repeat (5) @(negedge clk);
    wr(1, 1);
    wait_valid(n);
    chk(0, 32'h17, 32'h14, "R6 soft reset in flight");
    chk(PINS, 7, 3'b010, "R6 in-flight pins");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule